// File: doc/BRIEF.md
# Dual-Clock Sequential Frame Store

This block is a frame buffer with no address inputs. A video source pushes bytes into it at its own clock rate, and a processor later pulls them out at a different, unrelated clock rate. Each side keeps a private location pointer. The pointer moves forward by one location for every accepted byte. It goes back to location zero only when that side's own active-low pointer-clear strobe is sampled low. Bytes therefore come out in the order in which they went in.

A captured frame can be read any number of times. After a read-pointer clear, the same content is returned again from location zero. The expected order of use is:

1. Clear the write pointer.
2. Stream the frame in.
3. Clear the read pointer.
4. Stream the frame out.

No full, empty or overflow indication is produced. Both pointers wrap silently at the depth parameter.

The read side has two outputs:
- A registered byte with a one-cycle valid pulse, intended for observation.
- A bus output that drives that byte while output enable is low and floats otherwise.

The depth is a parameter. The full-size value is 393216 locations of 8 bits, which holds one frame. The defaults are small so that simulation stays cheap. Storage is behavioural, and no refresh is modelled.

Top module: `seqframe_store`

## Requirements
- R1: When wr_rst_n is low at a rising edge of wr_clk, the write pointer returns to location 0. This takes priority over wr_en_n, and no byte is stored on that edge.
- R2: When wr_en_n is low and wr_rst_n is high at a rising edge of wr_clk, wr_data is stored at the current write location and the write pointer advances by one.
- R3: When wr_en_n is high and wr_rst_n is high, no byte is stored and the write pointer holds. Bytes presented on such edges never appear in the read stream.
- R4: When rd_rst_n is low at a rising edge of rd_clk, the read pointer returns to location 0. This takes priority over rd_en_n and rd_oe_n, and rd_valid is 0 after that edge.
- R5: When rd_en_n and rd_oe_n are both low and rd_rst_n is high at a rising edge of rd_clk, the byte at the current read location appears on rd_q and the read pointer advances by one. rd_valid is 1 after that edge and reads 0 after any edge that does not perform a read.
- R6: When rd_en_n or rd_oe_n is high (with rd_rst_n high), reading is inhibited. rd_q and the read pointer hold, and rd_valid is 0 after that edge.
- R7: Bytes are read back in exactly the order in which they were stored.
- R8: After a read-pointer clear, the stored content is returned again from location 0, without rewriting.
- R9: Both pointers wrap from location DEPTH-1 to 0 with no indication. Writing DEPTH+k bytes after a write clear overwrites the first k locations.
- R10: rd_bus equals rd_q while rd_oe_n is low and is high-impedance while rd_oe_n is high.
- R11: wr_clk and rd_clk are independent. Data stored on one clock is read back correctly on another clock of a different frequency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_en_n | input | 1 | Write enable, active low |
| wr_rst_n | input | 1 | Write-pointer clear, active low, sampled on wr_clk |
| wr_data | input | DATA_W | Byte to store |
| rd_clk | input | 1 | Read-side clock |
| rd_en_n | input | 1 | Read enable, active low |
| rd_oe_n | input | 1 | Output enable, active low; also gates reading |
| rd_rst_n | input | 1 | Read-pointer clear, active low, sampled on rd_clk |
| rd_bus | output | DATA_W | Read byte while rd_oe_n is low, high-impedance otherwise |
| rd_q | output | DATA_W | Registered read byte |
| rd_valid | output | 1 | High for the cycle after an accepted read |

## Verification
The hardest situation to reach from the ports is silent wraparound. There both pointers cross location DEPTH-1 and the first locations are overwritten, while the rest of the frame must stay intact. The bench instantiates a 12-entry store. This exercises the compare-based wrap rather than the power-of-two one. It writes 14 bytes after a write clear and then reads 14 bytes after a read clear, so both pointers wrap and the overwritten and untouched locations are told apart. Clear-over-enable priority is reached by holding the enables active while the clears are low. A stray store on the clear edge would then shift the whole read stream by one byte.

// File: rtl/seqframe_pkg.sv
package seqframe_pkg;

   // Pointer width for a given depth (at least one bit)
   function automatic int unsigned sf_addr_w(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction

   // True when the depth is a power of two, so the pointer may wrap naturally
   function automatic bit sf_is_pow2(input int unsigned depth);
      return (depth != 0) && ((depth & (depth - 1)) == 0);
   endfunction

endpackage

// File: rtl/seqframe_ptr.sv
module seqframe_ptr
   import seqframe_pkg::*;
#(
   parameter int unsigned DEPTH = 1024,
   parameter int unsigned AW    = sf_addr_w(DEPTH)
) (
   input  logic          clk,
   input  logic          clr_n,
   input  logic          step,
   output logic [AW-1:0] ptr
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [AW-1:0] nxt;
   logic          armed = 1'b0;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("seqframe_ptr: DEPTH must be at least 2");
      end
      if (AW < sf_addr_w(DEPTH)) begin : g_bad_aw
         $error("seqframe_ptr: AW too narrow for DEPTH");
      end
      if (sf_is_pow2(DEPTH) && (AW == sf_addr_w(DEPTH))) begin : g_pow2
         assign nxt = ptr + 1'b1;
      end else begin : g_cmp
         assign nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!clr_n)     ptr <= '0;
      else if (step)  ptr <= nxt;
   end

   // Pointer state is defined only once a clear has been seen
   always_ff @(posedge clk) begin
      if (!clr_n) armed <= 1'b1;
   end

   AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!armed)
      !clr_n |=> (ptr == '0));                                         // R1, R4
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && !step) |=> $stable(ptr));                              // R3, R6
   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && step && ptr == LAST) |=> (ptr == '0));                 // R9
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!armed)
      (clr_n && step && ptr != LAST) |=> (ptr == AW'($past(ptr) + 1'b1))); // R2, R5

endmodule

// File: rtl/seqframe_mem.sv
module seqframe_mem
   import seqframe_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 1024,
   parameter int unsigned AW     = sf_addr_w(DEPTH)
) (
   input  logic              wr_clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rd_clk,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("seqframe_mem: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] store [DEPTH];

   // Write port: own clock domain
   always_ff @(posedge wr_clk) begin
      if (we) store[waddr] <= wdata;
   end

   // Read port: registered, updates only on an accepted read
   always_ff @(posedge rd_clk) begin
      if (re) rdata <= store[raddr];
   end

endmodule

// File: rtl/seqframe_store.sv
module seqframe_store
   import seqframe_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 1024
) (
   input  logic              wr_clk,
   input  logic              wr_en_n,
   input  logic              wr_rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_clk,
   input  logic              rd_en_n,
   input  logic              rd_oe_n,
   input  logic              rd_rst_n,
   output logic [DATA_W-1:0] rd_bus,
   output logic [DATA_W-1:0] rd_q,
   output logic              rd_valid
);

   localparam int unsigned AW = sf_addr_w(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("seqframe_store: DEPTH must be at least 2");
      end
   endgenerate

   logic [AW-1:0] wptr, rptr;
   logic          wr_go, rd_go;
   logic          rd_armed = 1'b0;

   // Clear has priority: no store and no read on a clear edge
   assign wr_go = wr_rst_n && !wr_en_n;
   assign rd_go = rd_rst_n && !rd_en_n && !rd_oe_n;

   seqframe_ptr #(.DEPTH(DEPTH), .AW(AW)) u_wptr (
      .clk   (wr_clk),
      .clr_n (wr_rst_n),
      .step  (wr_go),
      .ptr   (wptr)
   );

   seqframe_ptr #(.DEPTH(DEPTH), .AW(AW)) u_rptr (
      .clk   (rd_clk),
      .clr_n (rd_rst_n),
      .step  (rd_go),
      .ptr   (rptr)
   );

   seqframe_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .wr_clk (wr_clk),
      .we     (wr_go),
      .waddr  (wptr),
      .wdata  (wr_data),
      .rd_clk (rd_clk),
      .re     (rd_go),
      .raddr  (rptr),
      .rdata  (rd_q)
   );

   always_ff @(posedge rd_clk) begin
      rd_valid <= rd_go;
      if (!rd_rst_n) rd_armed <= 1'b1;
   end

   // Shared bus: driven only while output enable is active
   assign rd_bus = rd_oe_n ? {DATA_W{1'bz}} : rd_q;

   AST_RD_VALID_SRC: assert property (@(posedge rd_clk) disable iff (!rd_armed)
      rd_valid |-> $past(rd_rst_n && !rd_en_n && !rd_oe_n));           // R5
   AST_RD_CLR_NO_VALID: assert property (@(posedge rd_clk) disable iff (!rd_armed)
      !rd_rst_n |=> !rd_valid);                                        // R4
   AST_RD_Q_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_armed)
      (rd_en_n || rd_oe_n || !rd_rst_n) |=> $stable(rd_q));            // R6

endmodule

// File: tb/seqframe_store_bench.sv
`timescale 1ns/100ps
module seqframe_store_bench;

   localparam int DW    = 8;
   localparam int DEPTH = 12;
   localparam int NVEC  = 14;

   // Stimulus table: {wr_en_n, byte}; entries with wr_en_n=1 must be skipped (R3)
   localparam logic [8:0] WR_VEC [NVEC] = '{
      9'h0_3C, 9'h0_A1, 9'h1_FF, 9'h0_07, 9'h0_5E, 9'h1_EE,
      9'h0_90, 9'h0_12, 9'h0_C3, 9'h1_DD, 9'h0_6B, 9'h0_F0,
      9'h0_24, 9'h1_CC
   };

   logic wr_clk = 1'b0, rd_clk = 1'b0;
   logic wr_en_n = 1'b1, wr_rst_n = 1'b1, rd_en_n = 1'b1, rd_oe_n = 1'b1, rd_rst_n = 1'b1;
   logic [DW-1:0] wr_data = '0;
   wire  [DW-1:0] rd_bus;
   logic [DW-1:0] rd_q;
   logic          rd_valid;

   int checks = 0, errors = 0;
   logic [DW-1:0] exp_q [NVEC];
   int nexp = 0;
   logic [DW-1:0] sq, sbus;
   logic          sv;

   always #4   wr_clk = ~wr_clk;   // 125 MHz
   always #5.5 rd_clk = ~rd_clk;   // independent, slower read clock

   seqframe_store #(.DATA_W(DW), .DEPTH(DEPTH)) u_seqframe_store (
      .wr_clk, .wr_en_n, .wr_rst_n, .wr_data,
      .rd_clk, .rd_en_n, .rd_oe_n, .rd_rst_n,
      .rd_bus, .rd_q, .rd_valid
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_cycle(input logic en_n, input logic rst_n, input logic [DW-1:0] d);
      @(negedge wr_clk);
      wr_en_n = en_n; wr_rst_n = rst_n; wr_data = d;
      @(posedge wr_clk);
      #1;
   endtask

   task automatic wr_idle();
      @(negedge wr_clk);
      wr_en_n = 1'b1; wr_rst_n = 1'b1;
   endtask

   task automatic rd_cycle(input logic en_n, input logic oe_n, input logic rst_n);
      @(negedge rd_clk);
      rd_en_n = en_n; rd_oe_n = oe_n; rd_rst_n = rst_n;
      @(posedge rd_clk);
      #2;
      sq = rd_q; sv = rd_valid; sbus = rd_bus;
   endtask

   initial begin
      repeat (100000) @(posedge wr_clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // Reset state: clear both pointers with enables active (priority)
      wr_cycle(1'b0, 1'b0, 8'h99);                         // R1
      wr_idle();
      rd_cycle(1'b0, 1'b0, 1'b0);
      chk("R4 valid after clear", sv, 0);

      // Table walk: store, building the expected stream (R2, R3)
      for (int i = 0; i < NVEC; i++) begin
         wr_cycle(WR_VEC[i][8], 1'b1, WR_VEC[i][7:0]);
         if (!WR_VEC[i][8]) begin exp_q[nexp] = WR_VEC[i][7:0]; nexp++; end
      end
      wr_idle();

      // First four reads, in order (R5, R7, R11)
      for (int j = 0; j < 4; j++) begin
         rd_cycle(1'b0, 1'b0, 1'b1);
         chk("R7 order", sq, exp_q[j]);
         chk("R5 valid", sv, 1);
      end
      // Inhibited reads hold everything (R6); bus follows rd_q (R10)
      rd_cycle(1'b0, 1'b1, 1'b1);
      chk("R6 oe high valid", sv, 0);
      chk("R6 oe high hold", sq, exp_q[3]);
      rd_cycle(1'b1, 1'b0, 1'b1);
      chk("R6 en high valid", sv, 0);
      chk("R6 en high hold", sq, exp_q[3]);
      chk("R10 bus drives rd_q", sbus, exp_q[3]);
      // Remaining reads continue where the pointer was held (R2, R3, R7)
      for (int j = 4; j < nexp; j++) begin
         rd_cycle(1'b0, 1'b0, 1'b1);
         chk("R3 R7 stream", sq, exp_q[j]);
         chk("R10 bus", sbus, exp_q[j]);
      end

      // Re-read from start after a read clear with enables active (R4, R8)
      rd_cycle(1'b0, 1'b0, 1'b0);
      chk("R4 clear overrides read", sv, 0);
      chk("R4 clear holds rd_q", sq, exp_q[nexp-1]);
      for (int j = 0; j < nexp; j++) begin
         rd_cycle(1'b0, 1'b0, 1'b1);
         chk("R8 reread", sq, exp_q[j]);
      end

      // Write clear with wr_en_n low stores nothing (R1)
      wr_cycle(1'b0, 1'b0, 8'hEE);
      wr_cycle(1'b0, 1'b1, 8'h11);
      wr_cycle(1'b0, 1'b1, 8'h22);
      wr_idle();
      rd_cycle(1'b1, 1'b1, 1'b0);
      rd_cycle(1'b0, 1'b0, 1'b1);
      chk("R1 first after clear", sq, 8'h11);
      rd_cycle(1'b0, 1'b0, 1'b1);
      chk("R1 second after clear", sq, 8'h22);
      rd_cycle(1'b0, 1'b0, 1'b1);
      chk("R1 old content kept", sq, exp_q[2]);
      rd_cycle(1'b1, 1'b1, 1'b1);
      chk("R6 idle valid", sv, 0);

      // Wraparound on both pointers (R9)
      wr_cycle(1'b1, 1'b0, 8'h00);
      for (int i = 0; i < DEPTH + 2; i++) wr_cycle(1'b0, 1'b1, 8'((i * 7) + 3));
      wr_idle();
      rd_cycle(1'b1, 1'b1, 1'b0);
      for (int j = 0; j < DEPTH + 2; j++) begin
         int loc;
         loc = j % DEPTH;
         rd_cycle(1'b0, 1'b0, 1'b1);
         chk("R9 wrap", sq, (loc < 2) ? 8'(((DEPTH + loc) * 7) + 3) : 8'((loc * 7) + 3));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule